// File: doc/BRIEF.md
# DLL Master Lock Controller

This block is the synthesizable control logic for the master of a delay-locked loop. The master delay line, its phase detector and the clock derivation stay outside. The controller drives a tap-select word into that delay line. It watches a one-bit phase sample that says whether the delayed clock edge arrives at or after the reference edge. From that sample it finds the number of taps that spans one clock period. Everything runs on a single control clock. The phase sample comes from another clock domain, so it is resynchronised inside the block.

The controller starts searching when `enable` rises. It begins at tap zero and advances one tap per evaluation interval until the phase sample first reports a late edge. That event declares lock. If the line reaches its last tap and the sample is still early, the controller switches the measurement to the double-rate clock on its own and restarts the search. After lock, the controller follows slow drift one tap at a time. A step is taken only after a run of agreeing samples.

The 7-bit `quarter` word always gives a quarter of the single-rate period, in either measurement mode. Slaves read it while `locked` is high. The port list has no streaming data path, so every pin is a plain control or status level.

Top module: `dll_lock_ctrl`

## Requirements
- R1: While `rst_n` is low, `tap_sel`, `double_rate`, `locked` and `quarter` are all zero.
- R2: When `enable` is sampled low at a clock edge, then after that edge `tap_sel` is 0, `locked` is 0, `double_rate` is 0 and `quarter` is 0, from whatever state the block was in.
- R3: While searching (enabled, not locked), `tap_sel` changes only by +1. Successive steps are exactly EVAL_CYC (default 8) control-clock cycles apart. The only exception is the fallback restart of R5.
- R4: `phase_late` = 1 means the delayed edge is at or after the reference edge. The first evaluation that sees the synchronised sample at 1 sets `locked` and leaves `tap_sel` unchanged. For a delay line where a period spans N taps, lock occurs at `tap_sel` = N.
- R5: If the search is at the maximum tap (255 by default) in single-rate mode and the sample is still 0, `double_rate` goes to 1 and `tap_sel` restarts at 0. The search then continues.
- R6: `quarter` is 0 while `locked` is 0. While locked, it equals `tap_sel` >> 2 in single-rate mode (`double_rate` = 0) or `tap_sel` >> 1 in double-rate mode (`double_rate` = 1). It lags `tap_sel` by one cycle and saturates at 127.
- R7: While locked, consecutive changes of `tap_sel` are at least AGREE_N x EVAL_CYC cycles apart (default 24). A step needs AGREE_N consecutive evaluations with the same sample value.
- R8: While locked, `locked` and `double_rate` hold. `tap_sel` moves by one tap toward the period boundary: down after agreeing 1 samples, up after agreeing 0 samples. It is bounded by 0 and the maximum tap. It settles at N-1 or N and follows N when N drifts.
- R9: In double-rate mode, if the search reaches the maximum tap with the sample still 0, `tap_sel` holds at the maximum and `locked` stays 0 until `enable` drops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ctl | input | 1 | Control clock; all other pins are timed to it |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Start and keep the lock sequence; low returns to idle |
| phase_late | input | 1 | Raw phase-detector sample, 1 = delayed edge at or after reference |
| tap_sel | output | TAP_W (8) | Tap count driven into the master delay line |
| double_rate | output | 1 | 1 = measuring the double-rate clock period |
| locked | output | 1 | Master has locked; `quarter` is valid |
| quarter | output | 7 | Quarter of the single-rate period in slave taps |

## Verification
Most internal faults in this controller show up on `tap_sel` within one evaluation interval. Examples are an evaluation timer of the wrong length, a missed step or a wrong direction: the next step comes at the wrong spacing or goes the wrong way, or the lock tap differs from the period the delay-line model imposes. A fault in the agreement filter shows within AGREE_N intervals after lock, as dithering that is too fast. A fault in the quarter mapping or the mode fallback appears one cycle after lock, as the wrong `quarter` or `double_rate` for the chosen period.

// File: rtl/dll_lock_pkg.sv
package dll_lock_pkg;

  typedef enum logic [1:0] {
    LK_IDLE   = 2'd0,
    LK_SEARCH = 2'd1,
    LK_TRACK  = 2'd2
  } lock_state_e;

endpackage

// File: rtl/dll_phase_sync.sv
// Multi-stage synchroniser bringing the phase sample into the control domain.
module dll_phase_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[s] <= 1'b0;
        else        pipe[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[s] <= 1'b0;
        else        pipe[s] <= pipe[s-1];
      end
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/dll_eval_timer.sv
// Free-running interval counter; tick marks the last cycle of each interval.
module dll_eval_timer #(
  parameter int EVAL_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CNT_W = (EVAL_CYC > 1) ? $clog2(EVAL_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(EVAL_CYC - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!run)       cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                 cnt <= cnt + CNT_W'(1);
  end

  assign tick = run && (cnt == LAST);
endmodule

// File: rtl/dll_agree_filter.sv
// Counts consecutive equal phase samples; requests a one-tap step after AGREE_N.
module dll_agree_filter #(
  parameter int AGREE_N = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic tick,
  input  logic sample,
  output logic step_up,
  output logic step_dn
);
  localparam int CW = $clog2(AGREE_N + 1);
  localparam logic [CW-1:0] TARGET = CW'(AGREE_N);

  logic [CW-1:0] run_len;
  logic          last_s;
  logic [CW-1:0] next_len;
  logic          full;

  always_comb begin
    if (run_len != '0 && sample == last_s) next_len = run_len + CW'(1);
    else                                    next_len = CW'(1);
    full    = tick && (next_len == TARGET);
    step_up = full && !sample;
    step_dn = full &&  sample;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_len <= '0;
      last_s  <= 1'b0;
    end else if (clear) begin
      run_len <= '0;
      last_s  <= 1'b0;
    end else if (tick) begin
      last_s  <= sample;
      run_len <= full ? '0 : next_len;
    end
  end
endmodule

// File: rtl/dll_quarter_map.sv
// Registered conversion of the measured tap count to a single-rate quarter period.
module dll_quarter_map #(
  parameter int TAP_W = 8,
  parameter int QC_W  = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             valid,
  input  logic             dbl,
  input  logic [TAP_W-1:0] tap,
  output logic [QC_W-1:0]  quarter
);
  localparam int SH_W = TAP_W - 1;

  logic [SH_W-1:0] shifted;
  logic [QC_W-1:0] fitted;

  assign shifted = dbl ? tap[TAP_W-1:1] : {1'b0, tap[TAP_W-1:2]};

  if (SH_W > QC_W) begin : g_sat
    assign fitted = (|shifted[SH_W-1:QC_W]) ? {QC_W{1'b1}} : shifted[QC_W-1:0];
  end else begin : g_ext
    assign fitted = QC_W'(shifted);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      quarter <= '0;
    else if (clear)  quarter <= '0;
    else if (valid)  quarter <= fitted;
    else             quarter <= '0;
  end
endmodule

// File: rtl/dll_lock_ctrl.sv
module dll_lock_ctrl #(
  parameter int TAP_W    = 8,
  parameter int EVAL_CYC = 8,
  parameter int AGREE_N  = 3,
  parameter int SYNC_N   = 2
) (
  input  logic             clk_ctl,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             phase_late,
  output logic [TAP_W-1:0] tap_sel,
  output logic             double_rate,
  output logic             locked,
  output logic [6:0]       quarter
);
  import dll_lock_pkg::*;

  localparam int QC_W = 7;
  localparam logic [TAP_W-1:0] TAP_MAX = {TAP_W{1'b1}};

  lock_state_e      state;
  logic [TAP_W-1:0] tap_r;
  logic             dbl_r;
  logic             lock_r;
  logic             ph_sync;
  logic             tick;
  logic             step_up;
  logic             step_dn;

  dll_phase_sync #(.STAGES(SYNC_N)) u_sync (
    .clk   (clk_ctl),
    .rst_n (rst_n),
    .d     (phase_late),
    .q     (ph_sync)
  );

  dll_eval_timer #(.EVAL_CYC(EVAL_CYC)) u_timer (
    .clk   (clk_ctl),
    .rst_n (rst_n),
    .run   (enable && state != LK_IDLE),
    .tick  (tick)
  );

  dll_agree_filter #(.AGREE_N(AGREE_N)) u_agree (
    .clk     (clk_ctl),
    .rst_n   (rst_n),
    .clear   (state != LK_TRACK),
    .tick    (tick && state == LK_TRACK),
    .sample  (ph_sync),
    .step_up (step_up),
    .step_dn (step_dn)
  );

  always_ff @(posedge clk_ctl or negedge rst_n) begin
    if (!rst_n) begin
      state  <= LK_IDLE;
      tap_r  <= '0;
      dbl_r  <= 1'b0;
      lock_r <= 1'b0;
    end else if (!enable) begin
      state  <= LK_IDLE;
      tap_r  <= '0;
      dbl_r  <= 1'b0;
      lock_r <= 1'b0;
    end else begin
      unique case (state)
        LK_IDLE: state <= LK_SEARCH;
        LK_SEARCH: begin
          if (tick) begin
            if (ph_sync) begin
              state  <= LK_TRACK;
              lock_r <= 1'b1;
            end else if (tap_r == TAP_MAX) begin
              if (!dbl_r) begin
                dbl_r <= 1'b1;
                tap_r <= '0;
              end
            end else begin
              tap_r <= tap_r + TAP_W'(1);
            end
          end
        end
        LK_TRACK: begin
          if (step_up && tap_r != TAP_MAX)    tap_r <= tap_r + TAP_W'(1);
          else if (step_dn && tap_r != '0)    tap_r <= tap_r - TAP_W'(1);
        end
        default: state <= LK_IDLE;
      endcase
    end
  end

  dll_quarter_map #(.TAP_W(TAP_W), .QC_W(QC_W)) u_qmap (
    .clk     (clk_ctl),
    .rst_n   (rst_n),
    .clear   (!enable),
    .valid   (lock_r),
    .dbl     (dbl_r),
    .tap     (tap_r),
    .quarter (quarter)
  );

  assign tap_sel     = tap_r;
  assign double_rate = dbl_r;
  assign locked      = lock_r;
endmodule

// File: rtl/dll_lock_ctrl_chk.sv
module dll_lock_ctrl_chk #(
  parameter int TAP_W    = 8,
  parameter int EVAL_CYC = 8,
  parameter int AGREE_N  = 3
) (
  input logic             clk_ctl,
  input logic             rst_n,
  input logic             enable,
  input logic [TAP_W-1:0] tap_sel,
  input logic             double_rate,
  input logic             locked,
  input logic [6:0]       quarter
);
  localparam int GAP = AGREE_N * EVAL_CYC;

  logic [TAP_W-1:0] prev_tap;
  logic             prev_lock;
  logic [15:0]      since;
  logic             moved;

  assign moved = (tap_sel != prev_tap);

  always_ff @(posedge clk_ctl or negedge rst_n) begin
    if (!rst_n) begin
      prev_tap  <= '0;
      prev_lock <= 1'b0;
      since     <= 16'd1;
    end else begin
      prev_tap  <= tap_sel;
      prev_lock <= locked;
      if (!locked || moved)   since <= 16'd1;
      else if (since != '1)   since <= since + 16'd1;
    end
  end

  AST_OFF_CLEARS: assert property (@(posedge clk_ctl) disable iff (!rst_n)
    !enable |=> (tap_sel == '0 && !locked && !double_rate && quarter == '0)); // R2

  AST_TAP_UNIT_STEP: assert property (@(posedge clk_ctl) disable iff (!rst_n)
    (tap_sel != $past(tap_sel)) |->
      (tap_sel == $past(tap_sel) + TAP_W'(1) || $past(tap_sel) == tap_sel + TAP_W'(1) || tap_sel == '0)); // R3

  AST_LOCK_KEEPS_TAP: assert property (@(posedge clk_ctl) disable iff (!rst_n)
    $rose(locked) |-> $stable(tap_sel)); // R4

  AST_FALLBACK_AT_MAX: assert property (@(posedge clk_ctl) disable iff (!rst_n)
    $rose(double_rate) |-> ($past(tap_sel) == '1 && tap_sel == '0 && !locked)); // R5

  AST_QUARTER_IDLE: assert property (@(posedge clk_ctl) disable iff (!rst_n)
    !locked |-> quarter == '0); // R6

  AST_TRACK_SPACING: assert property (@(posedge clk_ctl) disable iff (!rst_n)
    (moved && locked && prev_lock) |-> (since >= 16'(GAP))); // R7

  AST_MODE_FROZEN: assert property (@(posedge clk_ctl) disable iff (!rst_n)
    (locked && $past(locked)) |-> $stable(double_rate)); // R8
endmodule

bind dll_lock_ctrl dll_lock_ctrl_chk #(
  .TAP_W    (TAP_W),
  .EVAL_CYC (EVAL_CYC),
  .AGREE_N  (AGREE_N)
) u_chk (
  .clk_ctl     (clk_ctl),
  .rst_n       (rst_n),
  .enable      (enable),
  .tap_sel     (tap_sel),
  .double_rate (double_rate),
  .locked      (locked),
  .quarter     (quarter)
);

// File: tb/test_dll_lock_ctrl.sv
module test_dll_lock_ctrl;
  localparam int TAP_W   = 8;
  localparam int EVAL    = 8;
  localparam int AGREE   = 3;
  localparam int TAP_MAX = (1 << TAP_W) - 1;
  localparam int GAP     = AGREE * EVAL;
  localparam int LOCK_LIMIT = EVAL * (2 * (TAP_MAX + 1) + 8) + 40;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             enable = 1'b0;
  logic             phase_late;
  logic [TAP_W-1:0] tap_sel;
  logic             double_rate;
  logic             locked;
  logic [6:0]       quarter;
  int               n1 = 100;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  // Delay-line model: a late edge once the tap count covers the measured period.
  assign phase_late = (int'(tap_sel) >= (double_rate ? (n1 >> 1) : n1));

  dll_lock_ctrl #(.TAP_W(TAP_W), .EVAL_CYC(EVAL), .AGREE_N(AGREE)) i_dll_lock_ctrl (
    .clk_ctl     (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .phase_late  (phase_late),
    .tap_sel     (tap_sel),
    .double_rate (double_rate),
    .locked      (locked),
    .quarter     (quarter)
  );

  function automatic int f_target(int n);
    return (n > TAP_MAX) ? (n >> 1) : n;
  endfunction

  function automatic int f_quarter(int tap, bit dbl);
    int q;
    q = dbl ? (tap >> 1) : (tap >> 2);
    return (q > 127) ? 127 : q;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Monitors for search spacing (R3, R5) and tracking spacing (R7)
  int  p_tap = 0;
  bit  p_en = 0, p_lock = 0, p_dbl = 0;
  int  s_gap = 0, t_gap = 1;
  bit  s_seen = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (enable && p_en && !locked && !p_lock && int'(tap_sel) != p_tap) begin
        if (tap_sel == 0) chk(double_rate && !p_dbl, "R5 fallback", int'(double_rate), 1);
        else begin
          chk(int'(tap_sel) == p_tap + 1, "R3 step", int'(tap_sel), p_tap + 1);
          if (s_seen) chk(s_gap == EVAL, "R3 spacing", s_gap, EVAL);
        end
        s_seen = 1;
        s_gap = 1;
      end else begin
        s_gap++;
      end
      if (!enable) s_seen = 0;

      if (locked && p_lock && int'(tap_sel) != p_tap)
        chk(t_gap >= GAP, "R7 track spacing", t_gap, GAP);
      if (!locked || int'(tap_sel) != p_tap) t_gap = 1;
      else t_gap++;

      p_tap = int'(tap_sel);
      p_en = enable;
      p_lock = locked;
      p_dbl = double_rate;
    end
  end

  task automatic expect_lock(int n);
    int cnt;
    n1 = n;
    @(negedge clk) enable = 1'b1;
    cnt = 0;
    while (!locked && cnt < LOCK_LIMIT) begin
      @(negedge clk);
      cnt++;
    end
    chk(locked, "R4 lock reached", int'(locked), 1);
    chk(int'(tap_sel) == f_target(n), "R4 lock tap", int'(tap_sel), f_target(n));
    chk(double_rate == (n > TAP_MAX), "R5 mode", int'(double_rate), int'(n > TAP_MAX));
    @(negedge clk);
    @(negedge clk);
    chk(int'(quarter) == f_quarter(f_target(n), n > TAP_MAX), "R6 quarter", int'(quarter),
        f_quarter(f_target(n), n > TAP_MAX));
  endtask

  task automatic track_check(int cycles);
    int t, prev;
    bit dbl;
    t = f_target(n1);
    dbl = (n1 > TAP_MAX);
    prev = int'(tap_sel);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      chk(int'(tap_sel) <= t && int'(tap_sel) + 1 >= t, "R8 settle", int'(tap_sel), t);
      chk(locked && double_rate == dbl, "R8 held", int'(locked), 1);
      chk(int'(quarter) == f_quarter(prev, dbl), "R6 track quarter", int'(quarter), f_quarter(prev, dbl));
      prev = int'(tap_sel);
    end
  endtask

  task automatic drop_enable();
    @(negedge clk) enable = 1'b0;
    @(negedge clk);
    chk(tap_sel == 0, "R2 tap", int'(tap_sel), 0);
    chk(!locked, "R2 locked", int'(locked), 0);
    chk(!double_rate, "R2 mode", int'(double_rate), 0);
    chk(quarter == 0, "R2 quarter", int'(quarter), 0);
    repeat (3) @(negedge clk);
    chk(tap_sel == 0 && !locked, "R2 idle hold", int'(tap_sel), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int seed;
    seed = $urandom(32'h5eed);
    repeat (3) @(negedge clk);
    chk(tap_sel == 0, "R1 tap", int'(tap_sel), 0);
    chk(!locked, "R1 locked", int'(locked), 0);
    chk(!double_rate, "R1 mode", int'(double_rate), 0);
    chk(quarter == 0, "R1 quarter", int'(quarter), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Directed: mid-range lock, then drift up and down
    expect_lock(100);
    track_check(150);
    n1 = 106;
    repeat (300) @(negedge clk);
    track_check(80);
    n1 = 97;
    repeat (400) @(negedge clk);
    track_check(80);
    drop_enable();

    // Corners: zero period, last single tap, first double, last double
    expect_lock(0);
    track_check(100);
    drop_enable();
    expect_lock(255);
    track_check(100);
    drop_enable();
    expect_lock(256);
    track_check(100);
    drop_enable();
    expect_lock(511);
    track_check(100);
    drop_enable();

    // R9: period too long for either mode
    n1 = 600;
    @(negedge clk) enable = 1'b1;
    repeat (EVAL * 2 * (TAP_MAX + 1) + 200) @(negedge clk);
    chk(!locked, "R9 no lock", int'(locked), 0);
    chk(int'(tap_sel) == TAP_MAX, "R9 tap held", int'(tap_sel), TAP_MAX);
    chk(double_rate, "R9 mode", int'(double_rate), 1);
    drop_enable();

    // R2 during search
    n1 = 200;
    @(negedge clk) enable = 1'b1;
    repeat (120) @(negedge clk);
    drop_enable();

    // Constrained random periods
    for (int k = 0; k < 8; k++) begin
      expect_lock(int'($urandom_range(1, 510)));
      track_check(60);
      drop_enable();
    end

    finish_run();
  end
endmodule